// File: doc/BRIEF.md
# Multi-Mode Phase Scale Generator

The block keeps a cyclic phase scale of 3600 steps, 0.1 degree per step, that other pulse logic uses as its common timing reference. Each step of the scale is one tick from the source selected by a two-bit mode code. Three sources are available. In locked mode a period-measuring digital loop multiplies a reference pin by a fixed factor of 40. The reference is expected to arrive already at 90 times the fundamental, so one fundamental period gives 3600 ticks. In free-running mode a phase accumulator adds a programmed step every clock, and its carry is the tick, so software sets the fundamental directly. In external mode the tick and a sync pulse come straight from pins, so several devices fed from the same pins stay in step.

A mode change is held until the scale wraps from 3599 to 0, so a cycle never skips or repeats a value. The one exception is the first cycle after reset. The source controller is a state machine with the states BOOT, LOCK, FREE and EXT. Its transitions are:
- BOOT to the requested source, one cycle after reset. A reserved code selects LOCK.
- From any source state to the decoded requested source, on the wrap.
- The reserved code 3 keeps the current state.

The reference multiplier is a second state machine:
- IDLE goes to MEASURE on the first reference edge.
- MEASURE goes to RUN on the next edge.
- RUN stays in RUN on each further edge.
- MEASURE and RUN go to IDLE when no edge arrives within the longest measurable period.

Top module: `phase_scale_gen`

## Requirements
- R1: `phase_o` stays within 0..3599. On a tick at 3599 it returns to 0, and `wrap_o` is high for exactly that one cycle.
- R2: In free-running mode (code 1) a tick occurs on each carry out of an NCO_W-bit accumulator that adds `nco_step_i` every clock. With the default width and a step of 2^22, the scale wraps every 14400 clocks.
- R3: In locked mode (code 0) with a stable reference, exactly 40 ticks fall in each reference period, so the phase advances by 40 per period.
- R4: The reference period is measured between synchronized rising edges. `lock_o` rises only after two consecutive measurements differ by at most LOCK_TOL clocks. After the first two edges it is still low.
- R5: `lock_o` drops when a measurement differs from the previous one by more than LOCK_TOL. It also drops when no reference edge arrives for 2^PERIOD_W-1 clocks.
- R6: In external mode (code 2) each rising edge on `ext_tick_i` advances the phase by one.
- R7: In external mode a rising edge on `ext_sync_i` sets the phase to 0 without a wrap strobe. Sync takes priority over a tick in the same cycle.
- R8: A new mode code takes effect only on a wrap. Until then the old source keeps advancing the scale, and afterwards the ticks of the other sources have no effect.
- R9: The reserved code 3 leaves the current source selected across a wrap.
- R10: After reset `phase_o` is 0 and `wrap_o` and `lock_o` are low. The requested source is adopted one cycle after reset.
- R11: The phase changes by at most one step per cycle: it moves to its successor, to 0, or not at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_req_i | input | 2 | Requested source: 0 locked, 1 free-running, 2 external, 3 keep |
| nco_step_i | input | NCO_W | Accumulator step for free-running mode |
| ref_i | input | 1 | Reference pulse train for locked mode |
| ext_tick_i | input | 1 | External tick pin |
| ext_sync_i | input | 1 | External sync pin, resets phase |
| phase_o | output | PH_W | Phase scale value, 0..3599 |
| wrap_o | output | 1 | One-cycle strobe on the return from 3599 to 0 |
| lock_o | output | 1 | Reference multiplier locked |

## Verification
Assertions check the following on every cycle:
- the phase range;
- the wrap strobe coinciding with a 3599-to-0 step;
- single-step phase movement;
- source changes happening only on a wrap;
- the cap of 40 ticks per reference period;
- lock being held only while the multiplier is running.

Only the bench scenarios can show rates and delays that span many cycles:
- the exact 14400-clock wrap interval in free-running mode;
- the advance of 40 per reference period;
- lock acquisition, loss on a period jump and loss on a timeout;
- the deferral of a mode request to the next wrap, and the ignoring of the sources that are not selected.

// File: rtl/phscale_pkg.sv
package phscale_pkg;
    typedef enum logic [1:0] {
        MODE_LOCK = 2'd0,
        MODE_FREE = 2'd1,
        MODE_EXT  = 2'd2,
        MODE_KEEP = 2'd3
    } mode_code_e;

    typedef enum logic [1:0] {
        SRC_BOOT,
        SRC_LOCK,
        SRC_FREE,
        SRC_EXT
    } src_state_e;

    typedef enum logic [1:0] {
        RM_IDLE,
        RM_MEASURE,
        RM_RUN
    } refmult_state_e;
endpackage

// File: rtl/phscale_pinsync.sv
module phscale_pinsync #(
    parameter int WIDTH = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] rise_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [2:0] sh_q;
        logic       rise_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                sh_q   <= '0;
                rise_q <= 1'b0;
            end else begin
                sh_q   <= {sh_q[1:0], pin_i[g]};
                rise_q <= sh_q[1] & ~sh_q[2];
            end
        end
        assign rise_o[g] = rise_q;
    end
endmodule

// File: rtl/phscale_nco.sv
module phscale_nco #(
    parameter int NCO_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NCO_W-1:0] step_i,
    output logic             tick_o
);
    logic [NCO_W-1:0] acc_q;
    logic [NCO_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, step_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            acc_q  <= sum[NCO_W-1:0];
            tick_o <= sum[NCO_W];
        end
    end
endmodule

// File: rtl/phscale_refmult.sv
module phscale_refmult
    import phscale_pkg::*;
#(
    parameter int PERIOD_W = 14,
    parameter int MULT     = 40,
    parameter int LOCK_TOL = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_rise_i,
    output logic tick_o,
    output logic lock_o
);
    localparam int AW   = PERIOD_W + 1;
    localparam int TC_W = $clog2(MULT + 1);

    refmult_state_e      state_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [AW-1:0]       period_q;
    logic [AW-1:0]       acc_q;
    logic [TC_W-1:0]     tcnt_q;
    logic                lock_q;

    logic [AW-1:0] new_period;
    logic [AW-1:0] diff;
    logic [AW:0]   sum;
    logic          timeout;
    logic          due;
    logic          room;

    assign new_period = {1'b0, cnt_q} + AW'(1);
    assign diff       = (new_period >= period_q) ? (new_period - period_q)
                                                 : (period_q - new_period);
    assign sum        = {1'b0, acc_q} + (AW + 1)'(MULT);
    assign timeout    = (cnt_q == '1);
    assign due        = (sum >= {1'b0, period_q});
    assign room       = (tcnt_q < TC_W'(MULT));

    // state register and measurement
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= RM_IDLE;
            cnt_q    <= '0;
            period_q <= '0;
            lock_q   <= 1'b0;
        end else if (ref_rise_i) begin
            cnt_q <= '0;
            unique case (state_q)
                RM_IDLE:    state_q <= RM_MEASURE;
                RM_MEASURE: begin
                    state_q  <= RM_RUN;
                    period_q <= new_period;
                end
                RM_RUN: begin
                    period_q <= new_period;
                    lock_q   <= (diff <= AW'(LOCK_TOL));
                end
                default:    state_q <= RM_IDLE;
            endcase
        end else if (timeout) begin
            state_q <= RM_IDLE;
            lock_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // fractional tick scheduler: MULT ticks spread over each period
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q  <= '0;
            tcnt_q <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (ref_rise_i) begin
                acc_q  <= AW'(MULT);
                tcnt_q <= '0;
            end else if (state_q == RM_RUN) begin
                if (due) begin
                    if (room) begin
                        acc_q  <= sum[AW-1:0] - period_q;
                        tcnt_q <= tcnt_q + 1'b1;
                        tick_o <= 1'b1;
                    end
                end else begin
                    acc_q <= sum[AW-1:0];
                end
            end
        end
    end

    assign lock_o = lock_q;

    assert_tick_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tcnt_q <= TC_W'(MULT));

    assert_lock_needs_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |-> (state_q == RM_RUN));
endmodule

// File: rtl/phscale_core.sv
module phscale_core
    import phscale_pkg::*;
#(
    parameter int STEPS = 3600,
    parameter int PH_W  = $clog2(STEPS)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [1:0]      mode_req_i,
    input  logic            tick_lock_i,
    input  logic            tick_free_i,
    input  logic            tick_ext_i,
    input  logic            sync_ext_i,
    output logic [PH_W-1:0] phase_o,
    output logic            wrap_o
);
    localparam logic [PH_W-1:0] LAST = PH_W'(STEPS - 1);

    src_state_e      state_q, state_d;
    logic [PH_W-1:0] phase_q;
    logic            wrap_q;
    logic            tick_sel;
    logic            sync_sel;
    logic            at_wrap;

    function automatic src_state_e decode(input logic [1:0] code, input src_state_e cur);
        unique case (mode_code_e'(code))
            MODE_LOCK: return SRC_LOCK;
            MODE_FREE: return SRC_FREE;
            MODE_EXT:  return SRC_EXT;
            default:   return (cur == SRC_BOOT) ? SRC_LOCK : cur;
        endcase
    endfunction

    always_comb begin
        tick_sel = 1'b0;
        sync_sel = 1'b0;
        unique case (state_q)
            SRC_BOOT: tick_sel = 1'b0;
            SRC_LOCK: tick_sel = tick_lock_i;
            SRC_FREE: tick_sel = tick_free_i;
            SRC_EXT: begin
                tick_sel = tick_ext_i;
                sync_sel = sync_ext_i;
            end
        endcase
    end

    assign at_wrap = tick_sel && !sync_sel && (phase_q == LAST);

    always_comb begin
        state_d = state_q;
        if (state_q == SRC_BOOT || at_wrap) begin
            state_d = decode(mode_req_i, state_q);
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SRC_BOOT;
        else         state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
            wrap_q  <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (sync_sel) begin
                phase_q <= '0;
            end else if (at_wrap) begin
                phase_q <= '0;
                wrap_q  <= 1'b1;
            end else if (tick_sel) begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign phase_o = phase_q;
    assign wrap_o  = wrap_q;

    assert_phase_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_q <= LAST);

    assert_wrap_from_top_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_q |-> (phase_q == '0 && $past(phase_q) == LAST));

    assert_single_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q != $past(phase_q)) |-> (phase_q == $past(phase_q) + 1'b1 || phase_q == '0));

    assert_switch_at_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != $past(state_q) && $past(state_q) != SRC_BOOT) |-> wrap_q);
endmodule

// File: rtl/phase_scale_gen.sv
module phase_scale_gen
    import phscale_pkg::*;
#(
    parameter int STEPS    = 3600,
    parameter int MULT     = 40,
    parameter int PERIOD_W = 14,
    parameter int LOCK_TOL = 4,
    parameter int NCO_W    = 24,
    parameter int PH_W     = $clog2(STEPS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       mode_req_i,
    input  logic [NCO_W-1:0] nco_step_i,
    input  logic             ref_i,
    input  logic             ext_tick_i,
    input  logic             ext_sync_i,
    output logic [PH_W-1:0]  phase_o,
    output logic             wrap_o,
    output logic             lock_o
);
    logic [2:0] rise;
    logic       tick_lock;
    logic       tick_free;

    phscale_pinsync #(.WIDTH(3)) pins_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  ({ext_sync_i, ext_tick_i, ref_i}),
        .rise_o (rise)
    );

    phscale_refmult #(
        .PERIOD_W (PERIOD_W),
        .MULT     (MULT),
        .LOCK_TOL (LOCK_TOL)
    ) mult_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ref_rise_i (rise[0]),
        .tick_o     (tick_lock),
        .lock_o     (lock_o)
    );

    phscale_nco #(.NCO_W(NCO_W)) nco_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (nco_step_i),
        .tick_o (tick_free)
    );

    phscale_core #(.STEPS(STEPS), .PH_W(PH_W)) core_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_req_i  (mode_req_i),
        .tick_lock_i (tick_lock),
        .tick_free_i (tick_free),
        .tick_ext_i  (rise[1]),
        .sync_ext_i  (rise[2]),
        .phase_o     (phase_o),
        .wrap_o      (wrap_o)
    );
endmodule

// File: tb/phase_scale_gen_tb.sv
module phase_scale_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_req = 2'd1;
    logic [23:0] nco_step = 24'h40_0000;
    logic        ref_p = 1'b0;
    logic        ext_tick = 1'b0;
    logic        ext_sync = 1'b0;
    logic [11:0] phase;
    logic        wrap;
    logic        lock;

    int checks = 0;
    int fails = 0;
    int wrap_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    phase_scale_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_req_i(mode_req), .nco_step_i(nco_step),
        .ref_i(ref_p), .ext_tick_i(ext_tick), .ext_sync_i(ext_sync),
        .phase_o(phase), .wrap_o(wrap), .lock_o(lock)
    );

    always @(posedge clk) if (wrap) wrap_cnt <= wrap_cnt + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_wrap();
        do @(negedge clk); while (!wrap);
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_tick = 1'b1; clks(2);
            ext_tick = 1'b0; clks(2);
        end
        clks(6);
    endtask

    task automatic ref_period(input int per, output int mid_phase);
        ref_p = 1'b1; clks(per / 2);
        mid_phase = phase;
        ref_p = 1'b0; clks(per - per / 2);
    endtask

    task automatic test_reset();
        check(phase == 0, "R10 phase at reset", phase, 0);
        check(wrap == 0, "R10 wrap at reset", wrap, 0);
        check(lock == 0, "R10 lock at reset", lock, 0);
    endtask

    task automatic test_free_rate();
        int n = 0;
        wait_wrap();
        do begin @(negedge clk); n++; end while (!wrap);
        check(n == 14400, "R2 free-running wrap interval", n, 14400);
        check(phase == 0, "R1 phase zero on wrap", phase, 0);
    endtask

    task automatic test_deferred_switch();
        int p0, p1;
        mode_req = 2'd2;
        p0 = phase;
        clks(40);
        p1 = phase;
        check((p1 + 3600 - p0) % 3600 == 10, "R8 old source runs until wrap",
              (p1 + 3600 - p0) % 3600, 10);
        wait_wrap();
        clks(200);
        check(phase == 0, "R8 free ticks ignored after switch to external", phase, 0);
    endtask

    task automatic test_ext_ticks_sync();
        int w0;
        ext_pulses(25);
        check(phase == 25, "R6 external ticks counted", phase, 25);
        w0 = wrap_cnt;
        ext_sync = 1'b1; clks(2); ext_sync = 1'b0; clks(6);
        check(phase == 0, "R7 sync clears phase", phase, 0);
        check(wrap_cnt == w0, "R7 sync gives no wrap strobe", wrap_cnt, w0);
    endtask

    task automatic test_reserved_keep();
        int w0 = wrap_cnt;
        mode_req = 2'd3;
        ext_pulses(3600);
        check(wrap_cnt == w0 + 1, "R1 external wrap strobe once", wrap_cnt, w0 + 1);
        check(phase == 0, "R1 external wrap to zero", phase, 0);
        clks(100);
        check(phase == 0, "R9 reserved code keeps external source", phase, 0);
        ext_pulses(3);
        check(phase == 3, "R9 external ticks still counted", phase, 3);
        mode_req = 2'd0;
        ext_pulses(3597);
        ext_pulses(5);
        check(phase == 0, "R8 external ticks ignored in locked mode", phase, 0);
    endtask

    task automatic test_lock();
        int m1, m2, dummy;
        ref_period(400, dummy);
        ref_period(400, dummy);
        check(lock == 0, "R4 no lock after two edges", lock, 0);
        ref_period(400, dummy);
        check(lock == 1, "R4 lock after matching periods", lock, 1);
        ref_period(400, m1);
        ref_period(400, m2);
        check((m2 + 3600 - m1) % 3600 == 40, "R3 advance per reference period",
              (m2 + 3600 - m1) % 3600, 40);
        ref_period(440, dummy);
        ref_period(400, dummy);
        check(lock == 0, "R5 lock lost on period jump", lock, 0);
        ref_period(400, dummy);
        ref_period(400, dummy);
        check(lock == 1, "R4 relock after stable periods", lock, 1);
        clks(17000);
        check(lock == 0, "R5 lock lost on reference timeout", lock, 0);
    endtask

    initial begin
        clks(5);
        test_reset();
        rst_n = 1'b1;
        test_free_rate();
        test_deferred_switch();
        test_ext_ticks_sync();
        test_reserved_keep();
        test_lock();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule